// File: doc/BRIEF.md
# Banked Command ROM Addresser

This block turns a key number into a 16-bit command word. The command is read from an internal ROM. That ROM is split into eight banks. A 3-bit bank register chooses the bank, and a captured key number chooses the entry inside it. Each entry spans two bytes. A fetch reads the low byte and then the high byte. It joins them and then signals, for a single clock, that the word is ready.

The bank register is loaded in one of two ways, chosen by a mode pin. In single-system mode, it takes the drive-select bits of the scan timer in any cycle where sense line 0 reads low. The bank therefore equals the number of the drive line that sense line 0 is strapped to. A strap to ground is only seen while every drive line is high, which is when the drive-select bits read 7. In multi-system mode, a key-driven pick strobe writes the bank directly. After reset the bank is 7 in both modes.

Top module: `cmd_rom_addresser`

## Requirements
- R1: After reset, the bank register is 7, the key register is 0, `rom_rd` is 0, `cmd_valid` is 0 and `cmd_word` is 0.
- R2: `rom_addr` is {bank[2:0], byte_sel, key[5:0]}, with the bank in bits 9:7, byte_sel in bit 6 (0 = low byte, 1 = high byte) and the key in bits 5:0. When no fetch is running, it shows the live bank register, byte_sel 0 and the last captured key.
- R3: A `fetch_req` sampled while idle captures `key_num`. In the next cycle `rom_rd` is 1 with byte_sel 0. In the cycle after that `rom_rd` is 1 with byte_sel 1. Then `rom_rd` returns to 0.
- R4: The ROM byte at address A is ((A*37) XOR (A>>4) XOR 0xA5) mod 256. The `cmd_word` is {high byte, low byte} of the fetched entry.
- R5: In single-system mode (`multi_mode`=0), a cycle with `sense0_n`=0 loads `scan_drive` into the bank register.
- R6: A sense line 0 strapped to ground is seen while `scan_drive`=7, so the bank becomes 7.
- R7: In multi-system mode, `bank_pick_we`=1 loads `bank_pick` into the bank register. `sense0_n` has no effect.
- R8: In single-system mode, `bank_pick_we` has no effect on the bank.
- R9: A fetch uses the bank register value as it stood in its request cycle. A bank load in that cycle or during the fetch only affects later fetches.
- R10: A `fetch_req` sampled while a fetch is running is ignored. The key register and the running fetch are unchanged.
- R11: `cmd_valid` is 1 for exactly one cycle, in the cycle after the high-byte read. `cmd_word` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_mode | input | 1 | 1 = multi-system bank selection, 0 = single-system |
| scan_drive | input | 3 | Drive-select bits of the scan timer |
| sense0_n | input | 1 | Sense line 0 level, low = active |
| bank_pick_we | input | 1 | Bank pick strobe (multi-system) |
| bank_pick | input | 3 | Bank value written by the pick strobe |
| fetch_req | input | 1 | Start a command fetch |
| key_num | input | 6 | Key number captured on a fetch request |
| rom_addr | output | 10 | ROM address {bank, byte_sel, key} |
| rom_rd | output | 1 | ROM read strobe |
| cmd_word | output | 16 | Assembled command word |
| cmd_valid | output | 1 | One-cycle completion flag |

## Verification
A bank load and the start of a fetch can happen in the same cycle. Load and fetch strobes can also keep arriving while the two byte reads are under way. The bench drives a sense-low or pick strobe together with `fetch_req`, and also during a running fetch. It then checks that the address high bits and the returned word belong to the bank that stood before the load. It also checks that the next idle address already shows the new bank. A behavioural model recomputes the address, strobe, word and flag every cycle from these rules and the ROM formula.

// File: rtl/cmd_rom_pkg.sv
package cmd_rom_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LO   = 2'd1,
      PH_HI   = 2'd2
   } fetch_phase_e;

   // ROM contents as a pure function of the address
   function automatic logic [31:0] rom_byte_of(input int unsigned a);
      logic [31:0] t;
      t = (a * 32'd37) ^ (a >> 4) ^ 32'h0000_00A5;
      return t & 32'h0000_00FF;
   endfunction

endpackage

// File: rtl/cmd_bank_reg.sv
module cmd_bank_reg #(
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              multi_mode,
   input  logic [BANK_W-1:0] scan_drive,
   input  logic              sense0_n,
   input  logic              pick_we,
   input  logic [BANK_W-1:0] pick,
   output logic [BANK_W-1:0] bank_q
);
   localparam logic [BANK_W-1:0] DEF_BANK = '1;

   logic              load_en;
   logic [BANK_W-1:0] load_val;

   always_comb begin
      load_en  = multi_mode ? pick_we : ~sense0_n;
      load_val = multi_mode ? pick    : scan_drive;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       bank_q <= DEF_BANK;
      else if (load_en) bank_q <= load_val;
   end

   // R7: pick strobe in multi-system mode
   a_r7_pick_load: assert property (@(posedge clk) disable iff (!rst_n)
      (multi_mode && pick_we) |=> (bank_q == $past(pick)));
   // R5: sense line 0 low in single-system mode
   a_r5_sense_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!multi_mode && !sense0_n) |=> (bank_q == $past(scan_drive)));
   // R8: no load condition keeps the bank
   a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((multi_mode && !pick_we) || (!multi_mode && sense0_n)) |=> $stable(bank_q));
endmodule

// File: rtl/cmd_rom.sv
module cmd_rom
   import cmd_rom_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int BYTE_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         logic [31:0] v;
         v = rom_byte_of(i);
         mem[i] = v[BYTE_W-1:0];
      end
   end

   assign rd_data = mem[addr];
endmodule

// File: rtl/cmd_fetch_seq.sv
module cmd_fetch_seq
   import cmd_rom_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int KEY_W  = 6,
   parameter int BYTE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch_req,
   input  logic [KEY_W-1:0]         key_in,
   input  logic [BANK_W-1:0]        bank_live,
   input  logic [BYTE_W-1:0]        rom_data,
   output logic [BANK_W+KEY_W:0]    rom_addr,
   output logic                     rom_rd,
   output logic [2*BYTE_W-1:0]      cmd_word,
   output logic                     cmd_valid
);
   localparam int SEL_BIT = KEY_W;
   localparam int ADDR_W  = BANK_W + 1 + KEY_W;

   fetch_phase_e      ph;
   logic [KEY_W-1:0]  key_q;
   logic [BANK_W-1:0] fbank_q;
   logic [BYTE_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         key_q     <= '0;
         fbank_q   <= '0;
         lo_q      <= '0;
         cmd_word  <= '0;
         cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= (ph == PH_HI);
         case (ph)
            PH_IDLE: if (fetch_req) begin
               key_q   <= key_in;
               fbank_q <= bank_live;
               ph      <= PH_LO;
            end
            PH_LO: begin
               lo_q <= rom_data;
               ph   <= PH_HI;
            end
            PH_HI: begin
               cmd_word <= {rom_data, lo_q};
               ph       <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      rom_rd   = (ph != PH_IDLE);
      rom_addr = {(ph == PH_IDLE) ? bank_live : fbank_q, (ph == PH_HI), key_q};
   end

   // R3: a read burst opens on the low byte
   a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_rd) |-> !rom_addr[SEL_BIT]);
   // R3: the low-byte read is followed by the high-byte read
   a_r3_high_next: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && !rom_addr[SEL_BIT]) |=> (rom_rd && rom_addr[SEL_BIT]));
   // R9: bank bits frozen across the two reads
   a_r9_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && rom_addr[SEL_BIT]) |-> $stable(rom_addr[ADDR_W-1 -: BANK_W]));
   // R10: key bits frozen across the two reads
   a_r10_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && rom_addr[SEL_BIT]) |-> $stable(rom_addr[KEY_W-1:0]));
   // R11: completion is a single-cycle pulse after the high read
   a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   a_r11_valid_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && rom_addr[SEL_BIT]) |=> cmd_valid);
endmodule

// File: rtl/cmd_rom_addresser.sv
module cmd_rom_addresser #(
   parameter int BANK_W = 3,
   parameter int KEY_W  = 6,
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  multi_mode,
   input  logic [BANK_W-1:0]     scan_drive,
   input  logic                  sense0_n,
   input  logic                  bank_pick_we,
   input  logic [BANK_W-1:0]     bank_pick,
   input  logic                  fetch_req,
   input  logic [KEY_W-1:0]      key_num,
   output logic [BANK_W+KEY_W:0] rom_addr,
   output logic                  rom_rd,
   output logic [2*BYTE_W-1:0]   cmd_word,
   output logic                  cmd_valid
);
   localparam int ADDR_W = BANK_W + 1 + KEY_W;

   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("BANK_W out of range");
   end
   if (KEY_W < BANK_W || ADDR_W > 12) begin : g_bad_key
      $error("KEY_W must cover the drive bits and keep the ROM small");
   end
   if (BYTE_W < 1 || BYTE_W > 16) begin : g_bad_byte
      $error("BYTE_W out of range");
   end

   logic [BANK_W-1:0] bank_q;
   logic [BYTE_W-1:0] rom_data;

   cmd_bank_reg #(.BANK_W(BANK_W)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .multi_mode (multi_mode),
      .scan_drive (scan_drive),
      .sense0_n   (sense0_n),
      .pick_we    (bank_pick_we),
      .pick       (bank_pick),
      .bank_q     (bank_q)
   );

   cmd_rom #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) rom_i (
      .addr    (rom_addr),
      .rd_data (rom_data)
   );

   cmd_fetch_seq #(.BANK_W(BANK_W), .KEY_W(KEY_W), .BYTE_W(BYTE_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_req (fetch_req),
      .key_in    (key_num),
      .bank_live (bank_q),
      .rom_data  (rom_data),
      .rom_addr  (rom_addr),
      .rom_rd    (rom_rd),
      .cmd_word  (cmd_word),
      .cmd_valid (cmd_valid)
   );
endmodule

// File: tb/cmd_rom_addresser_tb.sv
module cmd_rom_addresser_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        multi_mode = 1'b0;
   logic [2:0]  scan_drive = '0;
   logic        sense0_n = 1'b1;
   logic        bank_pick_we = 1'b0;
   logic [2:0]  bank_pick = '0;
   logic        fetch_req = 1'b0;
   logic [5:0]  key_num = '0;
   logic [9:0]  rom_addr;
   logic        rom_rd;
   logic [15:0] cmd_word;
   logic        cmd_valid;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   int m_bank, m_key, m_fbank, m_ph, m_lo, m_word, m_valid;

   always #2.5 clk = ~clk;

   cmd_rom_addresser dut_i (
      .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode), .scan_drive(scan_drive),
      .sense0_n(sense0_n), .bank_pick_we(bank_pick_we), .bank_pick(bank_pick),
      .fetch_req(fetch_req), .key_num(key_num), .rom_addr(rom_addr), .rom_rd(rom_rd),
      .cmd_word(cmd_word), .cmd_valid(cmd_valid)
   );

   // R4 content rule
   function automatic int exp_byte(int a);
      return ((a * 37) ^ (a >> 4) ^ 'hA5) & 255;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int ea;
      if (m_ph == 0) ea = (m_bank << 7) | m_key;
      else ea = (m_fbank << 7) | ((m_ph == 2) << 6) | m_key;
      chk("R2", "rom_addr", int'(rom_addr), ea);
      chk("R3", "rom_rd", int'(rom_rd), int'(m_ph != 0));
      chk("R11", "cmd_valid", int'(cmd_valid), m_valid);
      chk("R4", "cmd_word", int'(cmd_word), m_word);
   endtask

   task automatic model_edge();
      int nph;
      m_valid = (m_ph == 2);
      nph = m_ph;
      case (m_ph)
         0: if (fetch_req) begin m_key = key_num; m_fbank = m_bank; nph = 1; end // R10 when busy
         1: begin m_lo = exp_byte((m_fbank << 7) | m_key); nph = 2; end
         default: begin m_word = (exp_byte((m_fbank << 7) | 64 | m_key) << 8) | m_lo; nph = 0; end
      endcase
      m_ph = nph;
      if (multi_mode && bank_pick_we) m_bank = bank_pick;          // R7
      else if (!multi_mode && !sense0_n) m_bank = scan_drive;      // R5, R6
   endtask

   task automatic step(bit mm, int drv, bit s0n, bit we, int pk, bit rq, int key);
      multi_mode = mm; scan_drive = drv[2:0]; sense0_n = s0n;
      bank_pick_we = we; bank_pick = pk[2:0]; fetch_req = rq; key_num = key[5:0];
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(multi_mode, 0, 1, 0, 0, 0, 0);
   endtask

   initial begin
      m_bank = 7; m_key = 0; m_fbank = 0; m_ph = 0; m_lo = 0; m_word = 0; m_valid = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "reset rom_addr", int'(rom_addr), 'h380);
      chk("R1", "reset rom_rd", int'(rom_rd), 0);
      chk("R1", "reset cmd_valid", int'(cmd_valid), 0);
      chk("R1", "reset cmd_word", int'(cmd_word), 0);

      // R3 R4: plain fetch in bank 7
      step(0, 0, 1, 0, 0, 1, 5);
      idle(4);
      // R5: sense line 0 strapped to drive 3
      step(0, 3, 0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 1, 42);
      idle(4);
      // R6: grounded strap seen in all-high slots
      step(0, 7, 0, 0, 0, 0, 0);
      idle(1);
      // R8: pick strobe ignored in single-system mode
      step(0, 0, 1, 1, 2, 0, 0);
      idle(1);
      // R7: pick in multi-system mode, sense low ignored
      step(1, 0, 1, 1, 2, 0, 0);
      step(1, 5, 0, 0, 0, 0, 0);
      step(1, 0, 1, 0, 0, 1, 63);
      idle(4);
      // R9: load in the request cycle and during the fetch
      step(1, 0, 1, 1, 6, 1, 17);
      step(1, 0, 1, 1, 1, 0, 0);
      step(1, 0, 1, 0, 0, 0, 0);
      idle(2);
      // R10: request while busy, back-to-back requests
      step(0, 0, 1, 0, 0, 1, 9);
      step(0, 0, 1, 0, 0, 1, 33);
      step(0, 4, 0, 0, 0, 1, 34);
      step(0, 0, 1, 0, 0, 1, 35);
      idle(4);
      // mixed stimulus
      for (int i = 0; i < 600; i++) begin
         step(($urandom % 8) < 3, $urandom % 8, ($urandom % 4) != 0, ($urandom % 4) == 0,
              $urandom % 8, ($urandom % 3) == 0, $urandom % 64);
      end
      idle(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R3 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule